// File: doc/BRIEF.md
# Per-Run Reseeded Random Word Generator

This block gives a processor core pseudo-random words that can be read at any time without stalling. The words come from a wide linear feedback shift register. Each time a program run begins, the register is reseeded from an external entropy source. While the core is running, the register takes one step on every clock cycle. While the core is idle, it holds its value.

A single-cycle `run_start` pulse opens a seed transfer. The transfer uses a valid/ready pair: `seed_req` acts as the ready signal and `seed_valid` as the valid signal. The entropy source may raise `seed_valid` whenever it likes and must hold `seed_data` steady until it sees `seed_req` high at a clock edge. A word moves only in a cycle where both signals are high. Valid words offered while `seed_req` is low are not taken. The block keeps `seed_req` high for as long as the source is slow; a new run cannot start stepping from fresh entropy until the seed arrives. If `run_start` lands in the same cycle as a transfer, that word is still loaded and the request stays open for a further word.

The read side has two ports, and both are combinational from the register. The narrow control-register read port answers at address 0xFC2 with the low bits of the state. The wide-register read port answers at index 3 with the whole state. Each port returns zero when it is not addressed, so the core can OR it into its own read mux.

Top module: `run_lfsr_rng`

## Requirements
- R1: After reset, `seed_req` is low and the state equals the nonzero fallback constant (default value 1).
- R2: A `run_start` pulse makes `seed_req` high from the next cycle. It stays high while `seed_valid` is low and falls the cycle after a transfer, unless `run_start` is high again in that transfer cycle.
- R3: In a transfer cycle (`seed_req` and `seed_valid` both high), the nonzero `seed_data` becomes the state at that clock edge. This takes priority over stepping, even while `running` is high.
- R4: `seed_valid` and `seed_data` have no effect on the state while `seed_req` is low.
- R5: A transfer of an all-zero seed loads the fallback constant (default 1) instead, so the state is never zero.
- R6: While `running` is high and no transfer happens, each edge shifts the state left by one. The new bit 0 is the XOR of the state bits selected by the tap mask (default bits 255, 253, 250 and 245).
- R7: While `running` is low and no transfer happens, the state holds.
- R8: When `csr_addr` equals 0xFC2, `csr_rdata` returns state bits [CSR_W-1:0] in the same cycle; at any other address it returns 0.
- R9: When `wsr_idx` equals 3, `wsr_rdata` returns the whole state in the same cycle; at any other index it returns 0.
- R10: From any nonzero state, the stepping sequence returns to its start after exactly 2^WIDTH-1 steps and never passes through zero (checked at WIDTH=8 with tap mask 0xB8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | One-cycle pulse at the start of a program run |
| running | input | 1 | High while the core executes; enables stepping |
| seed_valid | input | 1 | Entropy source offers a seed word |
| seed_data | input | WIDTH | Seed word from the entropy source |
| seed_req | output | 1 | Ready for a seed; a transfer needs this and seed_valid |
| csr_addr | input | 12 | Control-register read address |
| csr_rdata | output | CSR_W | Low state bits when addressed, else 0 |
| wsr_idx | input | WSR_IDX_W | Wide-register read index |
| wsr_rdata | output | WIDTH | Full state when addressed, else 0 |

## Verification
The stepping function is checked against an arithmetic model over long stretches, first with `running` held high and then with `running` toggled in an irregular pattern. Comparing the two stretches separates a step that runs on every cycle from one that honours the enable. A reduced 8-bit instance has every one of its 256 seed values loaded, which separates the zero-seed substitution from plain loading. It is also run through its full cycle, which shows whether the taps give the maximal period. The seed handshake is tried in four ways: with a slow source, with valid offered while no request is open, with `run_start` arriving during a transfer, and with a transfer while `running` is high. These cases tell the request lifetime and the load priority apart from ordinary stepping.

// File: rtl/run_lfsr_pkg.sv
package run_lfsr_pkg;

  // Feedback mask for a 256-bit maximal-length register: bits 255, 253, 250, 245.
  localparam logic [255:0] TAPS_256 = (256'd1 << 255) | (256'd1 << 253) |
                                      (256'd1 << 250) | (256'd1 << 245);

  localparam logic [11:0] RND_CSR_ADDR = 12'hFC2;

  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_OPEN = 1'b1
  } seed_req_state_e;

endpackage

// File: rtl/rlfsr_seed_ctrl.sv
module rlfsr_seed_ctrl
  import run_lfsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_start,
  input  logic seed_valid,
  output logic seed_req,
  output logic seed_take
);

  seed_req_state_e st_q, st_d;

  assign seed_req  = (st_q == REQ_OPEN);
  assign seed_take = seed_req && seed_valid;

  always_comb begin
    st_d = st_q;
    if (run_start)      st_d = REQ_OPEN;
    else if (seed_take) st_d = REQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= REQ_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/rlfsr_state.sv
module rlfsr_state #(
  parameter int                 WIDTH    = 256,
  parameter logic [WIDTH-1:0]   TAPS     = run_lfsr_pkg::TAPS_256[WIDTH-1:0],
  parameter logic [WIDTH-1:0]   FALLBACK = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             advance,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  logic [WIDTH-1:0] state_q, state_d, stepped, seed_safe;
  logic             feedback;

  assign feedback  = ^(state_q & TAPS);
  assign stepped   = {state_q[WIDTH-2:0], feedback};
  assign seed_safe = (load_data == ALL_ZERO) ? FALLBACK : load_data;

  always_comb begin
    if (load)         state_d = seed_safe;
    else if (advance) state_d = stepped;
    else              state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FALLBACK;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/rlfsr_read_port.sv
module rlfsr_read_port #(
  parameter int              WIDTH     = 256,
  parameter int              CSR_W     = 32,
  parameter int              WSR_IDX_W = 3,
  parameter logic [11:0]     CSR_ADDR  = run_lfsr_pkg::RND_CSR_ADDR,
  parameter logic [WSR_IDX_W-1:0] WSR_IDX = WSR_IDX_W'(3)
) (
  input  logic [WIDTH-1:0]     state,
  input  logic [11:0]          csr_addr,
  input  logic [WSR_IDX_W-1:0] wsr_idx,
  output logic [CSR_W-1:0]     csr_rdata,
  output logic [WIDTH-1:0]     wsr_rdata
);

  logic csr_hit, wsr_hit;

  assign csr_hit = (csr_addr == CSR_ADDR);
  assign wsr_hit = (wsr_idx == WSR_IDX);

  for (genvar i = 0; i < CSR_W; i++) begin : g_csr_bit
    assign csr_rdata[i] = csr_hit & state[i];
  end

  for (genvar j = 0; j < WIDTH; j++) begin : g_wsr_bit
    assign wsr_rdata[j] = wsr_hit & state[j];
  end

endmodule

// File: rtl/run_lfsr_rng.sv
module run_lfsr_rng #(
  parameter int               WIDTH     = 256,
  parameter int               CSR_W     = 32,
  parameter int               WSR_IDX_W = 3,
  parameter logic [WIDTH-1:0] TAPS      = run_lfsr_pkg::TAPS_256[WIDTH-1:0],
  parameter logic [WIDTH-1:0] FALLBACK  = WIDTH'(1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_start,
  input  logic                 running,
  input  logic                 seed_valid,
  input  logic [WIDTH-1:0]     seed_data,
  output logic                 seed_req,
  input  logic [11:0]          csr_addr,
  output logic [CSR_W-1:0]     csr_rdata,
  input  logic [WSR_IDX_W-1:0] wsr_idx,
  output logic [WIDTH-1:0]     wsr_rdata
);

  logic             seed_take;
  logic [WIDTH-1:0] lfsr_state;

  rlfsr_seed_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_start  (run_start),
    .seed_valid (seed_valid),
    .seed_req   (seed_req),
    .seed_take  (seed_take)
  );

  rlfsr_state #(
    .WIDTH    (WIDTH),
    .TAPS     (TAPS),
    .FALLBACK (FALLBACK)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (seed_take),
    .load_data (seed_data),
    .advance   (running),
    .state     (lfsr_state)
  );

  rlfsr_read_port #(
    .WIDTH     (WIDTH),
    .CSR_W     (CSR_W),
    .WSR_IDX_W (WSR_IDX_W)
  ) u_read (
    .state     (lfsr_state),
    .csr_addr  (csr_addr),
    .wsr_idx   (wsr_idx),
    .csr_rdata (csr_rdata),
    .wsr_rdata (wsr_rdata)
  );

endmodule

// File: rtl/run_lfsr_rng_chk.sv
module run_lfsr_rng_chk #(
  parameter int               WIDTH     = 256,
  parameter int               CSR_W     = 32,
  parameter int               WSR_IDX_W = 3,
  parameter logic [WIDTH-1:0] FALLBACK  = WIDTH'(1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run_start,
  input logic                 running,
  input logic                 seed_valid,
  input logic [WIDTH-1:0]     seed_data,
  input logic                 seed_req,
  input logic [11:0]          csr_addr,
  input logic [CSR_W-1:0]     csr_rdata,
  input logic [WSR_IDX_W-1:0] wsr_idx,
  input logic [WIDTH-1:0]     wsr_rdata,
  input logic [WIDTH-1:0]     lfsr_state
);

  localparam logic [WIDTH-1:0] NONE = '0;

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> seed_req);

  assert_req_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req && !seed_valid |=> seed_req);

  assert_req_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req && seed_valid && !run_start |=> !seed_req);

  assert_seed_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req && seed_valid && (seed_data != NONE) |=> lfsr_state == $past(seed_data));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seed_req && seed_valid && (seed_data == NONE) |=> lfsr_state == FALLBACK);

  assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != NONE);

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running && !(seed_req && seed_valid) |=>
      lfsr_state[WIDTH-1:1] == $past(lfsr_state[WIDTH-2:0]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !(seed_req && seed_valid) |=> $stable(lfsr_state));

  assert_csr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_addr != 12'hFC2 |-> csr_rdata == '0);

  assert_wsr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wsr_idx != WSR_IDX_W'(3) |-> wsr_rdata == NONE);

endmodule

bind run_lfsr_rng run_lfsr_rng_chk #(
  .WIDTH     (WIDTH),
  .CSR_W     (CSR_W),
  .WSR_IDX_W (WSR_IDX_W),
  .FALLBACK  (FALLBACK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_start  (run_start),
  .running    (running),
  .seed_valid (seed_valid),
  .seed_data  (seed_data),
  .seed_req   (seed_req),
  .csr_addr   (csr_addr),
  .csr_rdata  (csr_rdata),
  .wsr_idx    (wsr_idx),
  .wsr_rdata  (wsr_rdata),
  .lfsr_state (lfsr_state)
);

// File: tb/run_lfsr_rng_test.sv
module run_lfsr_rng_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // Full-size instance
  logic         run_start = 0, running = 0, seed_valid = 0;
  logic [255:0] seed_data = '0;
  logic         seed_req;
  logic [11:0]  csr_addr = 12'hFC2;
  logic [31:0]  csr_rdata;
  logic [2:0]   wsr_idx = 3'd3;
  logic [255:0] wsr_rdata;

  run_lfsr_rng uut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .running(running),
    .seed_valid(seed_valid), .seed_data(seed_data), .seed_req(seed_req),
    .csr_addr(csr_addr), .csr_rdata(csr_rdata), .wsr_idx(wsr_idx), .wsr_rdata(wsr_rdata)
  );

  // Reduced 8-bit instance for exhaustive sweeps
  logic       s_start = 0, s_running = 0, s_valid = 0;
  logic [7:0] s_data = '0;
  logic       s_req;
  logic [3:0] s_csr;
  logic [7:0] s_wsr;

  run_lfsr_rng #(.WIDTH(8), .CSR_W(4), .WSR_IDX_W(3), .TAPS(8'hB8), .FALLBACK(8'h01)) uut_small (
    .clk(clk), .rst_n(rst_n), .run_start(s_start), .running(s_running),
    .seed_valid(s_valid), .seed_data(s_data), .seed_req(s_req),
    .csr_addr(12'hFC2), .csr_rdata(s_csr), .wsr_idx(3'd3), .wsr_rdata(s_wsr)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [255:0] model;

  function automatic logic [255:0] next256(input logic [255:0] v);
    return {v[254:0], v[255] ^ v[253] ^ v[250] ^ v[245]};
  endfunction

  function automatic logic [7:0] next8(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check(seed_req == 1'b0, "R1 seed_req after reset", 256'(seed_req), 256'd0);
    check(wsr_rdata == 256'd1, "R1 state after reset", wsr_rdata, 256'd1);
    model = 256'd1;

    // R8 / R9: selected and unselected reads
    check(csr_rdata == 32'd1, "R8 csr read at 0xFC2", 256'(csr_rdata), 256'd1);
    csr_addr = 12'hFC1; wsr_idx = 3'd2; #1;
    check(csr_rdata == 32'd0, "R8 csr read elsewhere", 256'(csr_rdata), 256'd0);
    check(wsr_rdata == '0, "R9 wsr read elsewhere", wsr_rdata, 256'd0);
    csr_addr = 12'hFC2; wsr_idx = 3'd3; #1;

    // R4: offered seed while no request is open
    seed_valid = 1; seed_data = {8{32'hA5A5_1234}};
    repeat (3) tick();
    check(wsr_rdata == model, "R4 seed ignored without request", wsr_rdata, model);
    check(seed_req == 1'b0, "R4 request stays closed", 256'(seed_req), 256'd0);
    seed_valid = 0;

    // R2: request lifetime with a slow source
    run_start = 1; tick(); run_start = 0;
    check(seed_req == 1'b1, "R2 request opens", 256'(seed_req), 256'd1);
    repeat (5) tick();
    check(seed_req == 1'b1, "R2 request held while source slow", 256'(seed_req), 256'd1);
    check(wsr_rdata == model, "R7 state holds while idle", wsr_rdata, model);

    // R3: transfer loads seed
    seed_valid = 1; seed_data = {8{32'hDEAD_BEEF}};
    tick(); seed_valid = 0;
    model = {8{32'hDEAD_BEEF}};
    check(seed_req == 1'b0, "R2 request closes after transfer", 256'(seed_req), 256'd0);
    check(wsr_rdata == model, "R3 seed loaded", wsr_rdata, model);
    check(csr_rdata == 32'hDEAD_BEEF, "R8 csr low slice", 256'(csr_rdata), 256'hDEAD_BEEF);

    // R6: continuous stepping
    running = 1;
    for (int i = 0; i < 400; i++) begin
      tick();
      model = next256(model);
      check(wsr_rdata == model, "R6 continuous step", wsr_rdata, model);
    end

    // R6 / R7: stepping under an irregular enable
    for (int i = 0; i < 400; i++) begin
      running = ((i % 3) != 0) && ((i % 7) != 5);
      tick();
      if (running) model = next256(model);
      check(wsr_rdata == model, "R7 enable-gated step", wsr_rdata, model);
    end

    // R3: transfer wins over stepping; R2: run_start during transfer keeps request open
    running = 1;
    run_start = 1; tick(); model = next256(model);
    seed_valid = 1; seed_data = {4{64'h0123_4567_89AB_CDEF}};
    tick(); run_start = 0; seed_valid = 0;
    model = {4{64'h0123_4567_89AB_CDEF}};
    check(wsr_rdata == model, "R3 load beats step", wsr_rdata, model);
    check(seed_req == 1'b1, "R2 restart during transfer keeps request", 256'(seed_req), 256'd1);
    model = next256(model);
    running = 0;

    // R5: zero seed replaced
    seed_valid = 1; seed_data = '0;
    tick(); seed_valid = 0;
    check(wsr_rdata == 256'd1, "R5 zero seed replaced", wsr_rdata, 256'd1);
    check(seed_req == 1'b0, "R2 request closes after zero seed", 256'(seed_req), 256'd0);

    // Reduced instance: exhaustive seed sweep (R3, R5)
    for (int v = 0; v < 256; v++) begin
      s_start = 1; tick(); s_start = 0;
      s_valid = 1; s_data = 8'(v); tick(); s_valid = 0;
      check(s_wsr == ((v == 0) ? 8'd1 : 8'(v)), (v == 0) ? "R5 small zero seed" : "R3 small seed sweep",
            256'(s_wsr), (v == 0) ? 256'd1 : 256'(v));
    end
    check(s_csr == 4'hF, "R8 narrow slice", 256'(s_csr), 256'hF);

    // R10: full period of the reduced instance from seed 1
    begin
      bit seen [256];
      int steps;
      logic [7:0] m8;
      bit repeat_or_zero;
      s_start = 1; tick(); s_start = 0;
      s_valid = 1; s_data = 8'h01; tick(); s_valid = 0;
      for (int k = 0; k < 256; k++) seen[k] = 0;
      seen[1] = 1;
      m8 = 8'h01;
      steps = 0;
      repeat_or_zero = 0;
      s_running = 1;
      do begin
        tick();
        steps++;
        m8 = next8(m8);
        if (s_wsr != m8) repeat_or_zero = 1;
        if (s_wsr != 8'h01) begin
          if (s_wsr == 8'h00 || seen[s_wsr]) repeat_or_zero = 1;
          seen[s_wsr] = 1;
        end
      end while (s_wsr != 8'h01 && steps < 300);
      s_running = 0;
      check(steps == 255, "R10 period length", 256'(steps), 256'd255);
      check(!repeat_or_zero, "R10 sequence distinct and nonzero", 256'(repeat_or_zero), 256'd0);
    end

    finish_run();
  end

endmodule